// File: doc/BRIEF.md
# Memory Address/Data Register Interface Unit

This unit connects a processor datapath to a word-addressed store and to a small keyboard and display register set. The processor loads an address register (MAR) and a data register (MDR) through two load strobes, then issues a read or a write request. The unit runs the access in a fixed order. A read places the addressed word into the MDR. A write puts the MDR contents at the MAR location. The unit then gives a one-cycle done pulse.

Addresses `0xFE00` to `0xFE07` are steered to four device registers and never reach the store. These are keyboard status, keyboard data, display status and display data. Typed key codes arrive on a strobe input. Words written to display data leave on a strobe output, and a ready flag tracks the display's recovery time.

A four-state machine runs every access. The states are IDLE, READ, WRITE and DONE. The transitions are:
- IDLE→READ on `rd_req`. A read request wins over a simultaneous write request.
- IDLE→WRITE on `wr_req` when `rd_req` is low.
- READ→DONE and WRITE→DONE unconditionally. The access commits on this edge.
- DONE→IDLE unconditionally.
- IDLE stays in IDLE when neither request is high.

Top module: `memif_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, MAR and MDR are 0, and the keyboard flag is 0. The display ready flag is 1, so a read of display status returns `0x8000`.
- R2: A request sampled in IDLE sets `busy` for the next two cycles, and `done` is high for only the second of them. The unit then returns to IDLE. Requests made while busy are ignored. When both requests arrive together, the read is performed.
- R3: A read returns in the MDR, during the done cycle, the word stored at the MAR address. The MAR value used is the one loaded in the same cycle as the request, if one was loaded then.
- R4: A write stores the MDR at the MAR address. The MDR value used is the one loaded in the same cycle as the request, if one was loaded then. The store has 2^MEM_AW words and is indexed by the low MEM_AW address bits, so addresses that differ only above those bits alias.
- R5: `mar_ld` and `mdr_ld` take effect only in IDLE. While busy, MAR and MDR keep their values, except that a read writes its result into the MDR.
- R6: Address bits [15:3] equal to `0x1FC0` select a device register, and bits [2:1] choose which one: 00 keyboard status, 01 keyboard data, 10 display status, 11 display data. Device accesses never touch the store. Writes to keyboard status, keyboard data and display status are ignored.
- R7: `key_strobe` loads `key_in` into keyboard data and sets keyboard status bit 15. All other status bits read 0. A read of keyboard data clears the bit. A key arriving on the same edge as that clear leaves the bit set.
- R8: Display status bit 15 (ready) drops on the edge that commits a display data write. It stays low for exactly DISP_BUSY cycles and then returns to 1. A new display write restarts the interval.
- R9: A display data write drives `disp_strobe` high for the one cycle after the commit edge, with `disp_data` holding the written word. `disp_data` holds that word until the next display write.
- R10: `mdr_out` always shows the MDR, so a word loaded with `mdr_ld` in IDLE appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mar_ld | input | 1 | Load MAR from `mar_in` (IDLE only) |
| mar_in | input | 16 | Address to load |
| mdr_ld | input | 1 | Load MDR from `mdr_in` (IDLE only) |
| mdr_in | input | 16 | Data to load |
| rd_req | input | 1 | Start a read |
| wr_req | input | 1 | Start a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mdr_out | output | 16 | Current MDR contents |
| key_strobe | input | 1 | New key code present |
| key_in | input | 16 | Key code |
| disp_strobe | output | 1 | Display word issued |
| disp_data | output | 16 | Last word written to display data |

## Verification
Call the edge that samples a request E0. `busy` rises after E0. The access commits on E0+1, so `done`, the read data in `mdr_out`, and `disp_strobe` with `disp_data` are all valid in the cycle after E0+1. Display ready is low for the DISP_BUSY cycles after the commit edge. A display status read therefore sees the flag as it stood just before that read's own commit edge. The bench drives inputs on falling edges, and a behavioural model advances on each rising edge. The model's outputs are compared with the DUT on every falling edge, and directed checks sample the done cycle of each access.

// File: rtl/memif_pkg.sv
package memif_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } memif_state_e;

    localparam logic [1:0] SEL_KEY_STAT  = 2'd0;
    localparam logic [1:0] SEL_KEY_DATA  = 2'd1;
    localparam logic [1:0] SEL_DISP_STAT = 2'd2;
    localparam logic [1:0] SEL_DISP_DATA = 2'd3;
endpackage

// File: rtl/memif_fsm.sv
module memif_fsm
    import memif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic busy,
    output logic done,
    output logic do_read,
    output logic do_write
);
    memif_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (rd_req)      state_nx = S_READ;
                else if (wr_req) state_nx = S_WRITE;
            end
            S_READ:  state_nx = S_DONE;
            S_WRITE: state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        do_read  = 1'b0;
        do_write = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_READ:  begin busy = 1'b1; do_read  = 1'b1; end
            S_WRITE: begin busy = 1'b1; do_write = 1'b1; end
            S_DONE:  begin busy = 1'b1; done     = 1'b1; end
        endcase
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && (rd_req || wr_req)) |=> busy);
    assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && rd_req) |=> do_read);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/memif_store.sv
module memif_store #(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/memif_devregs.sv
module memif_devregs
    import memif_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DISP_BUSY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [DATA_W-1:0] key_in,
    input  logic [1:0]        sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              disp_strobe,
    output logic [DATA_W-1:0] disp_data
);
    localparam int CNT_W = $clog2(DISP_BUSY + 1);

    logic              key_flag;
    logic [DATA_W-1:0] key_data;
    logic              disp_ready;
    logic [CNT_W-1:0]  ready_cnt;
    logic              disp_wr;

    assign disp_wr = wr_en && (sel == SEL_DISP_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_flag <= 1'b0;
            key_data <= '0;
        end else if (key_strobe) begin
            key_flag <= 1'b1;
            key_data <= key_in;
        end else if (rd_en && sel == SEL_KEY_DATA) begin
            key_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_ready  <= 1'b1;
            ready_cnt   <= '0;
            disp_strobe <= 1'b0;
            disp_data   <= '0;
        end else begin
            disp_strobe <= disp_wr;
            if (disp_wr) begin
                disp_data  <= wr_data;
                disp_ready <= 1'b0;
                ready_cnt  <= CNT_W'(DISP_BUSY);
            end else if (ready_cnt != '0) begin
                ready_cnt <= ready_cnt - 1'b1;
                if (ready_cnt == CNT_W'(1)) disp_ready <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_KEY_STAT:  rd_data = {key_flag, {(DATA_W-1){1'b0}}};
            SEL_KEY_DATA:  rd_data = key_data;
            SEL_DISP_STAT: rd_data = {disp_ready, {(DATA_W-1){1'b0}}};
            SEL_DISP_DATA: rd_data = disp_data;
        endcase
    end

    assert_key_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> key_flag);
    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_wr |=> !disp_ready);
    assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |-> !disp_ready);
endmodule

// File: rtl/memif_unit.sv
module memif_unit
    import memif_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                MEM_AW    = 8,
    parameter int                DISP_BUSY = 4,
    parameter logic [ADDR_W-1:0] DEV_BASE  = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_ld,
    input  logic [ADDR_W-1:0] mar_in,
    input  logic              mdr_ld,
    input  logic [DATA_W-1:0] mdr_in,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] mdr_out,
    input  logic              key_strobe,
    input  logic [DATA_W-1:0] key_in,
    output logic              disp_strobe,
    output logic [DATA_W-1:0] disp_data
);
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic              do_read, do_write, dev_hit;
    logic [DATA_W-1:0] mem_rdata, dev_rdata, rd_val;

    memif_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .busy(busy), .done(done), .do_read(do_read), .do_write(do_write)
    );

    assign dev_hit = (mar_q[ADDR_W-1:3] == DEV_BASE[ADDR_W-1:3]);

    memif_store #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_store (
        .clk(clk), .we(do_write && !dev_hit), .addr(mar_q[MEM_AW-1:0]),
        .wdata(mdr_q), .rdata(mem_rdata)
    );

    memif_devregs #(.DATA_W(DATA_W), .DISP_BUSY(DISP_BUSY)) u_dev (
        .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_in(key_in),
        .sel(mar_q[2:1]), .rd_en(do_read && dev_hit),
        .wr_en(do_write && dev_hit), .wr_data(mdr_q), .rd_data(dev_rdata),
        .disp_strobe(disp_strobe), .disp_data(disp_data)
    );

    assign rd_val = dev_hit ? dev_rdata : mem_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (!busy && mar_ld) mar_q <= mar_in;
            if (do_read)                 mdr_q <= rd_val;
            else if (!busy && mdr_ld)    mdr_q <= mdr_in;
        end
    end

    assign mdr_out = mdr_q;

    assert_mar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mar_q));
    assert_mdr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !do_read) |=> $stable(mdr_q));
    assert_done_after_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read || do_write) |=> done);
endmodule

// File: tb/memif_unit_bench.sv
module memif_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mar_ld = 0, mdr_ld = 0, rd_req = 0, wr_req = 0, key_strobe = 0;
    logic [15:0] mar_in = 0, mdr_in = 0, key_in = 0;
    logic        busy, done, disp_strobe;
    logic [15:0] mdr_out, disp_data;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    memif_unit u_memif_unit (
        .clk(clk), .rst_n(rst_n), .mar_ld(mar_ld), .mar_in(mar_in),
        .mdr_ld(mdr_ld), .mdr_in(mdr_in), .rd_req(rd_req), .wr_req(wr_req),
        .busy(busy), .done(done), .mdr_out(mdr_out), .key_strobe(key_strobe),
        .key_in(key_in), .disp_strobe(disp_strobe), .disp_data(disp_data)
    );

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // Behavioural reference model: 0 idle, 1 read, 2 write, 3 done
    int          m_phase;
    logic [15:0] m_mar, m_mdr, m_kdata, m_ddata;
    logic [15:0] m_mem [int];
    bit          m_kflag, m_ready, m_strobe;
    int          m_cnt;

    always @(posedge clk) begin
        logic [15:0] rv;
        bit dev, dwr;
        int ph;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_mar = 0; m_mdr = 0; m_kdata = 0; m_ddata = 0;
            m_kflag = 0; m_ready = 1; m_strobe = 0; m_cnt = 0;
        end else begin
            ph  = m_phase;
            dev = (m_mar[15:3] == 13'h1FC0);
            dwr = (ph == 2) && dev && (m_mar[2:1] == 2'd3);
            case (m_mar[2:1])
                2'd0: rv = m_kflag ? 16'h8000 : 16'h0000;
                2'd1: rv = m_kdata;
                2'd2: rv = m_ready ? 16'h8000 : 16'h0000;
                default: rv = m_ddata;
            endcase
            if (!dev) rv = m_mem.exists(int'(m_mar[7:0])) ? m_mem[int'(m_mar[7:0])] : 16'hxxxx;
            m_strobe = dwr;
            if (dwr) begin m_ready = 0; m_cnt = 4; m_ddata = m_mdr; end
            else if (m_cnt > 0) begin m_cnt--; if (m_cnt == 0) m_ready = 1; end
            if (ph == 1) begin
                m_mdr = rv;
                if (dev && m_mar[2:1] == 2'd1) m_kflag = 0;
            end
            if (ph == 2 && !dev) m_mem[int'(m_mar[7:0])] = m_mdr;
            if (key_strobe) begin m_kflag = 1; m_kdata = key_in; end
            case (ph)
                0: begin
                    if (mar_ld) m_mar = mar_in;
                    if (mdr_ld) m_mdr = mdr_in;
                    if (rd_req) m_phase = 1; else if (wr_req) m_phase = 2;
                end
                1, 2: m_phase = 3;
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            chk("R2 busy", {15'b0, busy}, {15'b0, m_phase != 0});
            chk("R2 done", {15'b0, done}, {15'b0, m_phase == 3});
            chk("R3 mdr_out", mdr_out, m_mdr);
            chk("R9 disp_strobe", {15'b0, disp_strobe}, {15'b0, m_strobe});
            chk("R9 disp_data", disp_data, m_ddata);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Drive an access starting at a falling edge; returns mdr_out in done cycle.
    task automatic access(bit wr, logic [15:0] addr, logic [15:0] data,
                          output logic [15:0] res, output bit dn);
        mar_ld = 1; mar_in = addr; rd_req = !wr; wr_req = wr;
        mdr_ld = wr; mdr_in = data;
        @(negedge clk);
        mar_ld = 0; mdr_ld = 0; rd_req = 0; wr_req = 0;
        @(negedge clk);
        res = mdr_out; dn = done;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] r;
        bit dn;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 busy", {15'b0, busy}, 16'd0);
        chk("R1 done", {15'b0, done}, 16'd0);
        chk("R1 mdr", mdr_out, 16'h0000);
        access(0, 16'hFE04, 0, r, dn); chk("R1 ready at reset", r, 16'h8000);
        access(0, 16'hFE00, 0, r, dn); chk("R1 key flag at reset", r, 16'h0000);
        // R3/R4 plain store traffic
        access(1, 16'h0010, 16'h1234, r, dn); chk("R2 write done", {15'b0, dn}, 16'd1);
        access(1, 16'h0020, 16'hBEEF, r, dn);
        access(0, 16'h0010, 0, r, dn); chk("R3 read 0x0010", r, 16'h1234);
        chk("R2 read done", {15'b0, dn}, 16'd1);
        access(0, 16'h0020, 0, r, dn); chk("R3 read 0x0020", r, 16'hBEEF);
        access(1, 16'h0110, 16'h5555, r, dn);
        access(0, 16'h0010, 0, r, dn); chk("R4 alias", r, 16'h5555);
        // R10 direct MDR load
        mdr_ld = 1; mdr_in = 16'hA5A5; @(negedge clk); mdr_ld = 0;
        chk("R10 mdr load", mdr_out, 16'hA5A5);
        // R5/R2: loads and requests while busy are ignored
        mar_ld = 1; mar_in = 16'h0020; rd_req = 1; @(negedge clk);
        mar_in = 16'h0030; mdr_ld = 1; mdr_in = 16'h9999; wr_req = 1; @(negedge clk);
        mar_ld = 0; mdr_ld = 0; rd_req = 0; wr_req = 0;
        chk("R5 mdr during busy", mdr_out, 16'hBEEF);
        @(negedge clk);
        chk("R2 idle after done", {15'b0, busy}, 16'd0);
        rd_req = 1; @(negedge clk); rd_req = 0; @(negedge clk);
        chk("R5 MAR kept", mdr_out, 16'hBEEF);
        @(negedge clk);
        // R2 read wins over write
        access(1, 16'h0030, 16'h1111, r, dn);
        mar_ld = 1; mar_in = 16'h0030; mdr_ld = 1; mdr_in = 16'h7777; rd_req = 1; wr_req = 1;
        @(negedge clk); mar_ld = 0; mdr_ld = 0; rd_req = 0; wr_req = 0;
        @(negedge clk); chk("R2 read priority", mdr_out, 16'h1111); @(negedge clk);
        // R6 device writes ignored and bypass store
        access(1, 16'h0002, 16'hAAAA, r, dn);
        access(1, 16'h0006, 16'hCCCC, r, dn);
        access(1, 16'hFE02, 16'h4242, r, dn);
        access(0, 16'hFE02, 0, r, dn); chk("R6 key data not writable", r, 16'h0000);
        access(1, 16'hFE00, 16'h8000, r, dn);
        access(0, 16'hFE00, 0, r, dn); chk("R6 key stat not writable", r, 16'h0000);
        access(0, 16'h0002, 0, r, dn); chk("R6 store untouched", r, 16'hAAAA);
        // R7 keyboard
        key_in = 16'h0061; key_strobe = 1; @(negedge clk); key_strobe = 0;
        access(0, 16'hFE00, 0, r, dn); chk("R7 flag set", r, 16'h8000);
        access(0, 16'hFE03, 0, r, dn); chk("R7 key data", r, 16'h0061);
        access(0, 16'hFE00, 0, r, dn); chk("R7 flag cleared", r, 16'h0000);
        key_in = 16'h0062; key_strobe = 1; @(negedge clk); key_strobe = 0;
        mar_ld = 1; mar_in = 16'hFE02; rd_req = 1; @(negedge clk);
        mar_ld = 0; rd_req = 0; key_in = 16'h0063; key_strobe = 1; @(negedge clk);
        key_strobe = 0; chk("R7 read old key", mdr_out, 16'h0062); @(negedge clk);
        access(0, 16'hFE00, 0, r, dn); chk("R7 new key wins", r, 16'h8000);
        // R8/R9 display
        mar_ld = 1; mar_in = 16'hFE06; mdr_ld = 1; mdr_in = 16'h0041; wr_req = 1;
        @(negedge clk); mar_ld = 0; mdr_ld = 0; wr_req = 0; @(negedge clk);
        chk("R9 strobe", {15'b0, disp_strobe}, 16'd1);
        chk("R9 data", disp_data, 16'h0041);
        @(negedge clk);
        chk("R9 strobe one cycle", {15'b0, disp_strobe}, 16'd0);
        access(0, 16'hFE04, 0, r, dn); chk("R8 ready low", r, 16'h0000);
        access(0, 16'hFE04, 0, r, dn); chk("R8 ready back", r, 16'h8000);
        access(1, 16'h0006, 16'h0000, r, dn);
        access(1, 16'hFE06, 16'h0042, r, dn);
        access(1, 16'hFE06, 16'h0043, r, dn);
        access(0, 16'hFE04, 0, r, dn); chk("R8 restart", r, 16'h0000);
        access(0, 16'hFE06, 0, r, dn); chk("R9 data readback", r, 16'h0043);
        access(0, 16'h0006, 0, r, dn); chk("R6 display write bypass", r, 16'h0000);
        repeat (6) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule